// File: doc/BRIEF.md
# Decode-Stage Hazard Stall Unit

This block sits in the decode stage of a five-stage in-order pipeline. In that pipeline the branch comparator and the target adder are also in decode. Each cycle it compares the two source register numbers of the instruction in decode with the destination numbers of the older instructions now in execute and memory. It also looks at whether each of those older instructions writes a register and whether it is a load.

When the result is not yet available, it raises a stall. A stall freezes the program counter and the fetch/decode register and clears the control fields going into execute, so a bubble enters the pipeline. A branch that resolves taken in decode and is not stalled produces a flush of the one instruction fetched behind it.

The number of stall cycles a branch suffers depends on its producer. An ALU producer one slot ahead costs one cycle. A load two slots ahead costs one cycle. A load directly ahead costs two cycles, because the bubble from the first stall moves the load into memory, where it still blocks the compare. The logic is purely combinational, so all outputs respond in the same cycle as their inputs.

Top module: `hazard_stall_unit`

## Requirements
- R1: When the execute-stage instruction is a load that writes a nonzero register equal to the decode rs or rt, the unit stalls: pc_write_o=0, ifid_write_o=0, ctrl_zero_o=1.
- R2: With no hazard, pc_write_o=1, ifid_write_o=1, ctrl_zero_o=0 and ifid_flush_o=0 (branch not taken).
- R3: A branch in decode whose rs or rt matches the nonzero destination of a register-writing non-load instruction in execute stalls.
- R4: A branch in decode whose rs or rt matches the nonzero destination of a load in memory stalls.
- R5: A branch directly behind a load that writes its compare register stalls for exactly two cycles: one while the load is in execute and one while it is in memory. It proceeds on the third cycle.
- R6: A register-writing non-load instruction in memory never stalls anything. A load in memory never stalls a non-branch instruction.
- R7: A destination of register 0, or an older instruction whose write flag is 0, never causes a stall.
- R8: A taken branch in decode that is not stalled drives ifid_flush_o=1 while pc_write_o=1.
- R9: Stall has priority over flush: while stalled, ifid_flush_o=0 even if the branch reports taken.
- R10: ctrl_zero_o is always the inverse of pc_write_o and ifid_write_o, and the two write enables are always equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| id_rs_i | input | REG_W | First source register of the decode instruction |
| id_rt_i | input | REG_W | Second source register of the decode instruction |
| id_is_branch_i | input | 1 | Decode instruction is a compare-and-branch on rs/rt |
| id_br_taken_i | input | 1 | Branch compare in decode resolves taken |
| ex_rd_i | input | REG_W | Destination register of the execute-stage instruction |
| ex_wr_i | input | 1 | Execute-stage instruction writes a register |
| ex_load_i | input | 1 | Execute-stage instruction reads memory |
| mem_rd_i | input | REG_W | Destination register of the memory-stage instruction |
| mem_wr_i | input | 1 | Memory-stage instruction writes a register |
| mem_load_i | input | 1 | Memory-stage instruction reads memory |
| pc_write_o | output | 1 | Program counter update enable |
| ifid_write_o | output | 1 | Fetch/decode register update enable |
| ctrl_zero_o | output | 1 | Clear control fields entering execute (bubble) |
| ifid_flush_o | output | 1 | Clear the fetch/decode register after a taken branch |

## Verification
Every output is a combinational function of the present inputs. Each result is therefore due in the same cycle as its stimulus, with no register on the path. The bench drives a new input set just after a rising edge and samples all four outputs at the following falling edge, half a period later, once everything has settled. The two-cycle branch-behind-load case is checked as a directed sequence: the load is presented in execute, then in memory, then gone. Each step is checked in its own cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_LOAD_USE = 2'd1,
    CAUSE_BR_EX    = 2'd2,
    CAUSE_BR_MEM   = 2'd3
  } stall_cause_e;
endpackage

// File: rtl/hz_dest_match.sv
module hz_dest_match #(
  parameter int REG_W = 5,
  parameter int SRC_N = 2
) (
  input  logic [REG_W-1:0]            dst_i,
  input  logic                        wr_i,
  input  logic [SRC_N-1:0][REG_W-1:0] src_i,
  output logic [SRC_N-1:0]            hit_o
);
  logic live;
  // register 0 is hardwired, never a real producer
  assign live = wr_i && (dst_i != '0);

  for (genvar g = 0; g < SRC_N; g++) begin : g_src
    assign hit_o[g] = live && (dst_i == src_i[g]);
  end
endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl
  import hz_pkg::*;
#(
  parameter int SRC_N = 2
) (
  input  logic [SRC_N-1:0] ex_hit_i,
  input  logic             ex_load_i,
  input  logic [SRC_N-1:0] mem_hit_i,
  input  logic             mem_load_i,
  input  logic             is_branch_i,
  output stall_cause_e     cause_o
);
  logic ex_any, mem_any;
  assign ex_any  = |ex_hit_i;
  assign mem_any = |mem_hit_i;

  always_comb begin
    cause_o = CAUSE_NONE;
    if (ex_any && ex_load_i)                     cause_o = CAUSE_LOAD_USE;
    else if (is_branch_i && ex_any)              cause_o = CAUSE_BR_EX;
    else if (is_branch_i && mem_any && mem_load_i) cause_o = CAUSE_BR_MEM;
  end
endmodule

// File: rtl/hazard_stall_unit.sv
module hazard_stall_unit
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs_i,
  input  logic [REG_W-1:0] id_rt_i,
  input  logic             id_is_branch_i,
  input  logic             id_br_taken_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             ex_wr_i,
  input  logic             ex_load_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_wr_i,
  input  logic             mem_load_i,
  output logic             pc_write_o,
  output logic             ifid_write_o,
  output logic             ctrl_zero_o,
  output logic             ifid_flush_o
);
  localparam int SRC_N = 2;

  logic [SRC_N-1:0][REG_W-1:0] srcs;
  logic [SRC_N-1:0]            ex_hit, mem_hit;
  stall_cause_e                cause;
  logic                        stall;

  assign srcs = {id_rt_i, id_rs_i};

  hz_dest_match #(.REG_W(REG_W), .SRC_N(SRC_N)) u_ex_match (
    .dst_i(ex_rd_i), .wr_i(ex_wr_i), .src_i(srcs), .hit_o(ex_hit)
  );

  hz_dest_match #(.REG_W(REG_W), .SRC_N(SRC_N)) u_mem_match (
    .dst_i(mem_rd_i), .wr_i(mem_wr_i), .src_i(srcs), .hit_o(mem_hit)
  );

  hz_stall_ctrl #(.SRC_N(SRC_N)) u_ctrl (
    .ex_hit_i   (ex_hit),
    .ex_load_i  (ex_load_i),
    .mem_hit_i  (mem_hit),
    .mem_load_i (mem_load_i),
    .is_branch_i(id_is_branch_i),
    .cause_o    (cause)
  );

  assign stall        = (cause != CAUSE_NONE);
  assign pc_write_o   = !stall;
  assign ifid_write_o = !stall;
  assign ctrl_zero_o  = stall;
  // a held branch re-resolves next cycle; flush only once released
  assign ifid_flush_o = id_is_branch_i && id_br_taken_i && !stall;

  always_comb begin
    if (ex_load_i && ex_wr_i && ex_rd_i != '0 && (ex_rd_i == id_rs_i || ex_rd_i == id_rt_i))
      AST_LOAD_USE_HOLDS: assert (!pc_write_o && ctrl_zero_o); // R1
    if (!ex_wr_i && !mem_wr_i)
      AST_NO_WRITER_NO_STALL: assert (pc_write_o); // R7
    if (ex_rd_i == '0 && mem_rd_i == '0)
      AST_ZERO_DEST_NO_STALL: assert (ifid_write_o); // R7
    if (!ex_wr_i && !mem_load_i)
      AST_MEM_ALU_NO_STALL: assert (pc_write_o); // R6
    AST_FLUSH_YIELDS_TO_STALL: assert (!(ifid_flush_o && ctrl_zero_o)); // R9
    AST_ENABLES_CONSISTENT: assert (pc_write_o == ifid_write_o && ctrl_zero_o == !pc_write_o); // R10
  end
endmodule

// File: tb/hazard_stall_unit_test.sv
module hazard_stall_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [REG_W-1:0] rs, rt, ex_rd, mem_rd;
  logic is_br, taken, ex_wr, ex_ld, mem_wr, mem_ld;
  logic pc_w, ifid_w, cz, fl;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  hazard_stall_unit #(.REG_W(REG_W)) uut (
    .id_rs_i(rs), .id_rt_i(rt), .id_is_branch_i(is_br), .id_br_taken_i(taken),
    .ex_rd_i(ex_rd), .ex_wr_i(ex_wr), .ex_load_i(ex_ld),
    .mem_rd_i(mem_rd), .mem_wr_i(mem_wr), .mem_load_i(mem_ld),
    .pc_write_o(pc_w), .ifid_write_o(ifid_w), .ctrl_zero_o(cz), .ifid_flush_o(fl)
  );

  function automatic logic hits(logic [REG_W-1:0] d, logic w);
    return w && d != 0 && (d == rs || d == rt);
  endfunction

  // expected outputs {pc_write, ifid_write, ctrl_zero, flush}
  function automatic logic [3:0] expect_out();
    logic st;
    st = (hits(ex_rd, ex_wr) && ex_ld)              // R1
       || (is_br && hits(ex_rd, ex_wr))             // R3
       || (is_br && hits(mem_rd, mem_wr) && mem_ld); // R4
    return {!st, !st, st, is_br && taken && !st};   // R8 R9
  endfunction

  task automatic drive(input logic [REG_W-1:0] a, b, input logic br, tk,
                       input logic [REG_W-1:0] er, input logic ew, el,
                       input logic [REG_W-1:0] mr, input logic mw, ml);
    @(posedge clk); #1;
    rs = a; rt = b; is_br = br; taken = tk;
    ex_rd = er; ex_wr = ew; ex_ld = el; mem_rd = mr; mem_wr = mw; mem_ld = ml;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {pc_w, ifid_w, cz, fl};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h1d5e;
    void'($urandom(seed));
    // reset / idle state
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0); check("R2 idle", 4'b1100);
    drive(3, 4, 0, 0, 7, 1, 0, 8, 1, 0); check("R2 unrelated", 4'b1100);
    // load-use on rs, on rt
    drive(3, 4, 0, 0, 3, 1, 1, 0, 0, 0); check("R1 rs", 4'b0010);
    drive(3, 4, 0, 0, 4, 1, 1, 0, 0, 0); check("R1 rt", 4'b0010);
    // branch behind ALU in execute
    drive(5, 6, 1, 1, 6, 1, 0, 0, 0, 0); check("R3 ex alu", 4'b0010);
    drive(5, 6, 0, 0, 6, 1, 0, 0, 0, 0); check("R3 nonbranch alu none", 4'b1100);
    // branch with load in memory
    drive(5, 6, 1, 0, 0, 0, 0, 5, 1, 1); check("R4 mem load", 4'b0010);
    // R5 sequence: load in ex, then in mem, then gone
    drive(9, 2, 1, 1, 9, 1, 1, 0, 0, 0); check("R5 cycle1", 4'b0010);
    drive(9, 2, 1, 1, 0, 0, 0, 9, 1, 1); check("R5 cycle2", 4'b0010);
    drive(9, 2, 1, 1, 0, 0, 0, 0, 0, 0); check("R5 cycle3", 4'b1101);
    // mem ALU for branch, mem load for non-branch
    drive(5, 6, 1, 0, 0, 0, 0, 5, 1, 0); check("R6 mem alu", 4'b1100);
    drive(5, 6, 0, 0, 0, 0, 0, 5, 1, 1); check("R6 mem load nonbranch", 4'b1100);
    // zero dest and no write
    drive(0, 0, 1, 0, 0, 1, 1, 0, 1, 1); check("R7 zero dest", 4'b1100);
    drive(3, 3, 1, 0, 3, 0, 1, 3, 0, 1); check("R7 no write", 4'b1100);
    // flush and priority
    drive(1, 2, 1, 1, 7, 1, 0, 7, 1, 1); check("R8 flush", 4'b1101);
    drive(1, 2, 1, 1, 1, 1, 0, 0, 0, 0); check("R9 stall over flush", 4'b0010);
    // random mix on a narrow register range to force matches
    for (int i = 0; i < 400; i++) begin
      logic [3:0] e;
      drive(REG_W'($urandom_range(0, 3)), REG_W'($urandom_range(0, 3)),
            1'($urandom), 1'($urandom),
            REG_W'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
            REG_W'($urandom_range(0, 3)), 1'($urandom), 1'($urandom));
      e = expect_out();
      check("R10 random", e);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule